// File: doc/BRIEF.md
# Interrupt Request and Acknowledge Unit

This unit sits on the processor side of a simple interrupt handshake. An external device asks for service with a single-clock pulse on the request input; the unit remembers that request in a pending flag so that the pulse is never lost. It waits until the core says it is ready to take an interrupt and the shared 8-bit I/O bus is free. Then it raises the acknowledge output for exactly two clocks.

The first acknowledge clock is a quiet clock, and nothing is taken from the bus during it. In the second clock the device places a byte on the I/O bus, and the unit samples it at the end of that clock. The sampled byte is then handed to the core together with a single-cycle valid strobe. A request that arrives while an acknowledge is running is held over and served by a second sequence after the current one ends.

Top module: `irq_ack_unit`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising clock edge, the next cycle shows `ack_out` = 0 and `vec_valid` = 0, and any pending request is discarded.
- R2: A request pulse on `irq_in` that lasts one clock is held as pending until it is served. It is still served if the core becomes ready many cycles later.
- R3: An acknowledge sequence starts only at a clock edge where a request is pending, `core_ready` = 1 and `bus_busy` = 0. `ack_out` rises in the cycle after that edge.
- R4: Once `ack_out` rises, it stays high for exactly two consecutive cycles and then falls.
- R5: `bus_data` is ignored during the first acknowledge cycle. The captured byte equals the value of `bus_data` at the clock edge that ends the second acknowledge cycle.
- R6: `vec_valid` is high for exactly one cycle, the cycle right after `ack_out` falls, and `vec_data` then shows the captured byte. `vec_data` keeps that byte until the next capture.
- R7: A request pulse that arrives during either acknowledge cycle gives exactly one further acknowledge sequence after the current one ends.
- R8: Several request pulses that arrive while a request is already pending and no sequence has started give a single acknowledge sequence.
- R9: With no pending request, `ack_out` stays low whatever `core_ready` and `bus_busy` do.
- R10: A reset during an acknowledge sequence drops `ack_out` in the next cycle and gives no capture strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 1 | Interrupt request pulse from a device |
| core_ready | input | 1 | Core is able to take an interrupt now |
| bus_busy | input | 1 | Shared I/O bus is in use by another transfer |
| bus_data | input | DATA_W (8) | Shared I/O bus data, sampled in the second acknowledge cycle |
| ack_out | output | 1 | Interrupt acknowledge, high for two cycles per sequence |
| vec_data | output | DATA_W (8) | Byte captured from the bus |
| vec_valid | output | 1 | One-cycle strobe marking a fresh `vec_data` |

## Verification
The bench changes the bus byte on every cycle. A design that sampled in the quiet first cycle, or one cycle late, would hand the core the wrong byte. Requests are placed exactly on the first and on the second acknowledge cycle. A design that cleared the pending flag at the start of a sequence, or that ignored requests during the capture edge, would lose the follow-up sequence. A burst of pulses while the core is not ready must give one sequence and not several. Ready and busy are toggled on their own to show that neither one alone can start an acknowledge. A reset in the middle of a sequence must cut `ack_out` and must not produce a stray strobe.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_QUIET = 2'd1,
    SEQ_FETCH = 2'd2
  } seq_state_t;

  // A sequence may begin only with a held request, a willing core and a free bus.
  function automatic logic may_start(input logic held, input logic ready, input logic busy);
    return held & ready & ~busy;
  endfunction

  // Order of the acknowledge phases.
  function automatic seq_state_t advance(input seq_state_t cur, input logic go);
    case (cur)
      SEQ_IDLE:  return go ? SEQ_QUIET : SEQ_IDLE;
      SEQ_QUIET: return SEQ_FETCH;
      default:   return SEQ_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic in_seq,
  input  logic seq_done,
  output logic pending
);

  logic follow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      follow_q <= 1'b0;
    end else if (seq_done) begin
      // The served request retires; a follow-up or a fresh pulse stays pending.
      pending  <= follow_q | req;
      follow_q <= 1'b0;
    end else if (in_seq) begin
      follow_q <= follow_q | req;
    end else begin
      pending  <= pending | req;
    end
  end

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_ack_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pending,
  input  logic core_ready,
  input  logic bus_busy,
  output logic seq_start,
  output logic seq_done,
  output logic in_seq,
  output logic ack
);

  seq_state_t state_q;

  assign seq_start = (state_q == SEQ_IDLE) && may_start(pending, core_ready, bus_busy);
  assign seq_done  = (state_q == SEQ_FETCH);
  assign in_seq    = (state_q != SEQ_IDLE);
  assign ack       = in_seq;

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEQ_IDLE;
    else     state_q <= advance(state_q, seq_start);
  end

endmodule

// File: rtl/irq_vec_capture.sv
module irq_vec_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [DATA_W-1:0] bus_data,
  output logic [DATA_W-1:0] vec_data,
  output logic              vec_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_data  <= '0;
      vec_valid <= 1'b0;
    end else begin
      vec_valid <= take;
      if (take) vec_data <= bus_data;
    end
  end

endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_in,
  input  logic              core_ready,
  input  logic              bus_busy,
  input  logic [DATA_W-1:0] bus_data,
  output logic              ack_out,
  output logic [DATA_W-1:0] vec_data,
  output logic              vec_valid
);

  logic pending;
  logic seq_start;
  logic seq_done;
  logic in_seq;

  irq_req_latch u_latch (
    .clk      (clk),
    .rst      (rst),
    .req      (irq_in),
    .in_seq   (in_seq),
    .seq_done (seq_done),
    .pending  (pending)
  );

  irq_ack_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .pending    (pending),
    .core_ready (core_ready),
    .bus_busy   (bus_busy),
    .seq_start  (seq_start),
    .seq_done   (seq_done),
    .in_seq     (in_seq),
    .ack        (ack_out)
  );

  irq_vec_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .take      (seq_done),
    .bus_data  (bus_data),
    .vec_data  (vec_data),
    .vec_valid (vec_valid)
  );

endmodule

// File: rtl/irq_ack_checker.sv
module irq_ack_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              core_ready,
  input logic              bus_busy,
  input logic [DATA_W-1:0] bus_data,
  input logic              ack_out,
  input logic [DATA_W-1:0] vec_data,
  input logic              vec_valid,
  input logic              pending,
  input logic              seq_start,
  input logic              seq_done
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!ack_out && !vec_valid));

  assert_pending_held_R2: assert property (@(posedge clk) disable iff (rst)
    (pending && !seq_done) |=> pending);

  assert_start_gate_R3: assert property (@(posedge clk) disable iff (rst)
    seq_start |-> (pending && core_ready && !bus_busy));

  assert_ack_second_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_out) |=> ack_out);

  assert_ack_ends_R4: assert property (@(posedge clk) disable iff (rst)
    (ack_out && $past(ack_out)) |=> !ack_out);

  assert_capture_byte_R5: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (vec_data == $past(bus_data)));

  assert_valid_place_R6: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> ($past(ack_out) && !ack_out));

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> !vec_valid);

  assert_idle_no_ack_R9: assert property (@(posedge clk) disable iff (rst)
    (!ack_out && !pending) |=> !ack_out);

endmodule

bind irq_ack_unit irq_ack_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .core_ready (core_ready),
  .bus_busy   (bus_busy),
  .bus_data   (bus_data),
  .ack_out    (ack_out),
  .vec_data   (vec_data),
  .vec_valid  (vec_valid),
  .pending    (pending),
  .seq_start  (seq_start),
  .seq_done   (seq_done)
);

// File: tb/irq_ack_unit_tb.sv
module irq_ack_unit_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       irq_in = 1'b0;
  logic       core_ready = 1'b0;
  logic       bus_busy = 1'b0;
  logic [7:0] bus_data = 8'h00;
  logic       ack_out;
  logic [7:0] vec_data;
  logic       vec_valid;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rises = 0;
  int strobes = 0;
  bit prev_ack = 1'b0;

  // behavioural reference state
  int  m_phase = 0;
  bit  m_pend = 1'b0;
  bit  m_extra = 1'b0;
  bit  m_vld = 1'b0;
  int  m_cap = 0;

  always #2 clk = ~clk;

  irq_ack_unit u_dut (
    .clk        (clk),
    .rst        (rst),
    .irq_in     (irq_in),
    .core_ready (core_ready),
    .bus_busy   (bus_busy),
    .bus_data   (bus_data),
    .ack_out    (ack_out),
    .vec_data   (vec_data),
    .vec_valid  (vec_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_edge();
    int  ph;
    bit  pd, ex, go;
    ph = m_phase; pd = m_pend; ex = m_extra;
    if (rst) begin
      m_phase = 0; m_pend = 0; m_extra = 0; m_vld = 0;
    end else begin
      go = (ph == 0) && pd && core_ready && !bus_busy;
      m_vld = (ph == 2);
      if (ph == 2) m_cap = bus_data;
      if (ph == 2) begin m_pend = ex | irq_in; m_extra = 0; end
      else if (ph == 1) m_extra = ex | irq_in;
      else m_pend = pd | irq_in;
      if (ph == 0) m_phase = go ? 1 : 0;
      else if (ph == 1) m_phase = 2;
      else m_phase = 0;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #1;
    chk(ack_out == (m_phase != 0), "R4 ack level", ack_out, m_phase != 0);
    chk(vec_valid == m_vld, "R6 strobe", vec_valid, m_vld);
    if (m_vld) chk(vec_data == 8'(m_cap), "R5 byte", vec_data, m_cap);
    if (ack_out && !prev_ack) rises++;
    prev_ack = ack_out;
    if (vec_valid) strobes++;
    cyc++;
    bus_data = 8'(cyc * 37 + 11);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse();
    irq_in = 1'b1;
    tick();
    irq_in = 1'b0;
  endtask

  initial begin
    int r0;
    int s0;
    int lfsr;
    // R1 reset state
    ticks(3);
    chk(ack_out == 0 && vec_valid == 0, "R1 reset outputs", ack_out, 0);
    rst = 1'b0;
    // R9 no request, ready toggling
    core_ready = 1'b1;
    ticks(3);
    bus_busy = 1'b1; ticks(2); bus_busy = 1'b0; ticks(2);
    chk(rises == 0, "R9 no ack without request", rises, 0);

    // basic sequence (R4, R5, R6)
    r0 = rises; s0 = strobes;
    pulse();
    ticks(6);
    chk(rises == r0 + 1, "R4 one sequence", rises - r0, 1);
    chk(strobes == s0 + 1, "R6 one strobe", strobes - s0, 1);

    // R2 and R3: gated start
    core_ready = 1'b0;
    r0 = rises;
    pulse();
    ticks(8);
    chk(rises == r0, "R3 no start while not ready", rises - r0, 0);
    core_ready = 1'b1; bus_busy = 1'b1;
    ticks(5);
    chk(rises == r0, "R3 no start while bus busy", rises - r0, 0);
    bus_busy = 1'b0;
    ticks(6);
    chk(rises == r0 + 1, "R2 late service", rises - r0, 1);

    // R7 request during first acknowledge cycle
    r0 = rises;
    pulse();             // edge sets pending
    tick();              // start edge -> first ack cycle visible
    chk(ack_out == 1, "R7 in first ack cycle", ack_out, 1);
    pulse();             // request during first ack cycle
    ticks(10);
    chk(rises == r0 + 2, "R7 follow-up after first-cycle request", rises - r0, 2);

    // R7 request during second acknowledge cycle
    r0 = rises;
    pulse();
    ticks(2);            // now in second ack cycle
    chk(ack_out == 1, "R7 in second ack cycle", ack_out, 1);
    pulse();
    ticks(10);
    chk(rises == r0 + 2, "R7 follow-up after second-cycle request", rises - r0, 2);

    // R8 burst while waiting gives one sequence
    core_ready = 1'b0;
    r0 = rises;
    pulse(); tick(); pulse(); pulse(); tick(); pulse();
    ticks(3);
    core_ready = 1'b1;
    ticks(10);
    chk(rises == r0 + 1, "R8 burst merged", rises - r0, 1);

    // R10 reset mid-sequence
    r0 = rises; s0 = strobes;
    pulse();
    tick();
    chk(ack_out == 1, "R10 sequence running", ack_out, 1);
    rst = 1'b1;
    tick();
    chk(ack_out == 0 && vec_valid == 0, "R10 ack cut by reset", ack_out, 0);
    rst = 1'b0;
    ticks(8);
    chk(strobes == s0 && rises == r0 + 1, "R10 no capture or restart", strobes - s0, 0);

    // mixed stimulus compared to the model every cycle
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0);
      irq_in     = (lfsr[2:0] == 3'd0);
      core_ready = (lfsr[5:3] != 3'd0);
      bus_busy   = (lfsr[8:6] == 3'd7);
      tick();
    end
    irq_in = 1'b0;
    ticks(6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule